// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block takes one multi-register memory transfer instruction and turns it into a serial stream of simple micro-operations for a back end that only handles single-register operations. The instruction gives a base register, a 16-bit register list and five mode flags: up/down, pre/post stepping, a privileged-mode bit, base writeback and load/store.

Every accepted instruction starts with a copy of the base register into a scratch address register, index 17. One load or store then follows for each register in the list, lowest index first. Each of these carries an offset from the scratch register, and that offset moves by 4 per register. If writeback is asked for, a last micro-op adds or subtracts four times the register count to or from the base register.

Micro-ops leave the block one per cycle on a valid/ready handshake, and the final one is flagged. A flag combination the block does not support is refused with a one-cycle error pulse, and no micro-op is produced for it.

Top module: `lsm_uop_sequencer`

## Requirements
- R1: After reset `in_ready` is 1 and `uop_valid`, `bad_req` and `uop_total` are 0.
- R2: The first micro-op of an accepted instruction has opcode MOV (code 0), `uop_reg` 17, `uop_base` equal to the instruction's base register and immediate 0.
- R3: Each set bit of the list produces exactly one transfer micro-op, in ascending bit order. Its opcode is LOAD (code 3) when the load flag is 1 and STORE (code 4) otherwise, `uop_reg` is the bit index and `uop_base` is 17.
- R4: The first transfer's offset is 0 in post mode, +4 in pre mode with up set, and -4 in pre mode with up clear. Each later transfer's offset is the previous one plus 4 (up) or minus 4 (down).
- R5: When writeback is set, the final micro-op is ADDI (code 1) when up is set, otherwise SUBI (code 2). Its `uop_reg` and `uop_base` are the base register and its immediate is four times the number of set list bits.
- R6: `uop_last` is 1 on the final micro-op of an instruction and 0 on every other one.
- R7: An instruction with the privileged-mode bit set is unsupported. Accepting it gives `bad_req` high for exactly the one cycle after acceptance, no micro-op is issued, and `in_ready` stays 1.
- R8: An empty register list produces the MOV followed only by the writeback micro-op when writeback is requested.
- R9: While `uop_valid` is 1 and `uop_ready` is 0, all micro-op outputs hold their values. No micro-op is lost or reordered.
- R10: `in_ready` is 0 whenever a micro-op is being presented. A new instruction is taken only when the block is idle.
- R11: From the cycle after a supported instruction is accepted, `uop_total` equals 1 + (number of set list bits) + (1 if writeback, else 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle and able to take an instruction |
| in_base | input | 4 | Base register index |
| in_list | input | 16 | Register list, bit i selects register i |
| in_up | input | 1 | 1: addresses rise, 0: addresses fall |
| in_pre | input | 1 | 1: step before the first access |
| in_s | input | 1 | Privileged-mode bit (unsupported when 1) |
| in_wb | input | 1 | Update the base register at the end |
| in_load | input | 1 | 1: load, 0: store |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_op | output | 3 | 0 MOV, 1 ADDI, 2 SUBI, 3 LOAD, 4 STORE |
| uop_reg | output | 5 | Destination or data register index |
| uop_base | output | 5 | Base register index of the micro-op |
| uop_imm | output | 10 | Signed offset or immediate |
| uop_last | output | 1 | Final micro-op of the instruction |
| bad_req | output | 1 | Unsupported instruction refused |
| uop_total | output | 5 | Micro-op count of the current instruction |

## Verification
A corrupted remaining-register mask shows up within one transfer as a wrong or repeated register index. It can also show up as a stream that is one micro-op too long or too short, and the closing `uop_last` then falls on the wrong micro-op. A stuck or skipped offset step makes every later transfer's immediate wrong, so a 16-register list exposes it on the second transfer. A broken state register either drops the writeback or makes `in_ready` rise while micro-ops are still pending, and both are visible the cycle it happens. Random back-pressure on `uop_ready` checks that stalls leave every field unchanged.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    OP_MOV   = 3'd0,
    OP_ADDI  = 3'd1,
    OP_SUBI  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } uop_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_XFER = 2'd2,
    ST_WB   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lsm_lowbit_finder.sv
module lsm_lowbit_finder #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [W-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | vec[i];
    assign onehot[i]  = vec[i] & ~seen[i];
  end

  assign any = seen[W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/lsm_mask_walker.sv
module lsm_mask_walker #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  input  logic             consume,
  output logic [IDX_W-1:0] low_idx,
  output logic             any,
  output logic [W-1:0]     rest
);
  logic [W-1:0] rem_q;
  logic [W-1:0] pick;

  lsm_lowbit_finder #(.W(W), .IDX_W(IDX_W)) u_find (
    .vec    (rem_q),
    .onehot (pick),
    .idx    (low_idx),
    .any    (any)
  );

  assign rest = rem_q & ~pick;

  always_ff @(posedge clk) begin
    if (!rst_n)       rem_q <= '0;
    else if (load)    rem_q <= load_val;
    else if (consume) rem_q <= rest;
  end
endmodule

// File: rtl/lsm_offset_acc.sv
module lsm_offset_acc #(
  parameter int IMM_W = 10,
  parameter int STEP  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [IMM_W-1:0] start,
  input  logic                    step_en,
  input  logic                    up,
  output logic signed [IMM_W-1:0] off
);
  localparam logic signed [IMM_W-1:0] STEP_V = IMM_W'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)       off <= '0;
    else if (load)    off <= start;
    else if (step_en) off <= up ? off + STEP_V : off - STEP_V;
  end
endmodule

// File: rtl/lsm_uop_sequencer.sv
module lsm_uop_sequencer
  import lsm_pkg::*;
#(
  parameter int LIST_W  = 16,
  parameter int BASE_W  = 4,
  parameter int REG_W   = 5,
  parameter int IMM_W   = 10,
  parameter int TMP_REG = 17,
  parameter int STEP    = 4,
  localparam int IDX_W  = $clog2(LIST_W),
  localparam int CNT_W  = $clog2(LIST_W + 3)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BASE_W-1:0]       in_base,
  input  logic [LIST_W-1:0]       in_list,
  input  logic                    in_up,
  input  logic                    in_pre,
  input  logic                    in_s,
  input  logic                    in_wb,
  input  logic                    in_load,
  output logic                    uop_valid,
  input  logic                    uop_ready,
  output logic [2:0]              uop_op,
  output logic [REG_W-1:0]        uop_reg,
  output logic [REG_W-1:0]        uop_base,
  output logic signed [IMM_W-1:0] uop_imm,
  output logic                    uop_last,
  output logic                    bad_req,
  output logic [CNT_W-1:0]        uop_total
);
  localparam logic [REG_W-1:0] TMP_IDX = REG_W'(TMP_REG);

  function automatic logic [CNT_W-1:0] f_popcount(input logic [LIST_W-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < LIST_W; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic signed [IMM_W-1:0] f_start_off(input logic pre, input logic up);
    logic signed [IMM_W-1:0] s;
    s = IMM_W'(STEP);
    if (!pre)    return '0;
    else if (up) return s;
    else         return -s;
  endfunction

  function automatic logic f_supported(input logic s_bit);
    return !s_bit;
  endfunction

  function automatic logic [CNT_W-1:0] f_total(input logic [LIST_W-1:0] m, input logic wb);
    return CNT_W'(1) + f_popcount(m) + CNT_W'(wb);
  endfunction

  seq_state_e st_q, st_d;
  logic [REG_W-1:0]  base_q;
  logic              up_q, wb_q, load_q, bad_q;
  logic [CNT_W-1:0]  pop_q, total_q;

  // named internal events
  logic accept, accept_ok, accept_bad, fire, xfer_fire;
  logic walk_any, walk_done;
  logic [IDX_W-1:0]  walk_idx;
  logic [LIST_W-1:0] walk_rest;
  logic signed [IMM_W-1:0] cur_off, wb_imm;

  assign in_ready   = (st_q == ST_IDLE);
  assign uop_valid  = (st_q != ST_IDLE);
  assign accept     = in_valid && in_ready;
  assign accept_ok  = accept && f_supported(in_s);
  assign accept_bad = accept && !f_supported(in_s);
  assign fire       = uop_valid && uop_ready;
  assign xfer_fire  = fire && (st_q == ST_XFER);
  assign walk_done  = (walk_rest == '0);
  assign wb_imm     = IMM_W'(pop_q) * IMM_W'(STEP);

  lsm_mask_walker #(.W(LIST_W), .IDX_W(IDX_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_ok),
    .load_val (in_list),
    .consume  (xfer_fire),
    .low_idx  (walk_idx),
    .any      (walk_any),
    .rest     (walk_rest)
  );

  lsm_offset_acc #(.IMM_W(IMM_W), .STEP(STEP)) u_off (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_ok),
    .start   (f_start_off(in_pre, in_up)),
    .step_en (xfer_fire),
    .up      (up_q),
    .off     (cur_off)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_ok) st_d = ST_MOVE;
      ST_MOVE: if (fire) st_d = walk_any ? ST_XFER : (wb_q ? ST_WB : ST_IDLE);
      ST_XFER: if (fire) st_d = !walk_done ? ST_XFER : (wb_q ? ST_WB : ST_IDLE);
      ST_WB:   if (fire) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      up_q    <= 1'b0;
      wb_q    <= 1'b0;
      load_q  <= 1'b0;
      pop_q   <= '0;
      total_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      bad_q <= accept_bad;
      if (accept_ok) begin
        base_q  <= REG_W'(in_base);
        up_q    <= in_up;
        wb_q    <= in_wb;
        load_q  <= in_load;
        pop_q   <= f_popcount(in_list);
        total_q <= f_total(in_list, in_wb);
      end
    end
  end

  always_comb begin
    uop_op   = OP_MOV;
    uop_reg  = '0;
    uop_base = '0;
    uop_imm  = '0;
    uop_last = 1'b0;
    unique case (st_q)
      ST_MOVE: begin
        uop_op   = OP_MOV;
        uop_reg  = TMP_IDX;
        uop_base = base_q;
        uop_last = !walk_any && !wb_q;
      end
      ST_XFER: begin
        uop_op   = load_q ? OP_LOAD : OP_STORE;
        uop_reg  = REG_W'(walk_idx);
        uop_base = TMP_IDX;
        uop_imm  = cur_off;
        uop_last = walk_done && !wb_q;
      end
      ST_WB: begin
        uop_op   = up_q ? OP_ADDI : OP_SUBI;
        uop_reg  = base_q;
        uop_base = base_q;
        uop_imm  = wb_imm;
        uop_last = 1'b1;
      end
      default: ;
    endcase
  end

  assign bad_req   = bad_q;
  assign uop_total = total_q;
endmodule

// File: rtl/lsm_uop_checker.sv
module lsm_uop_checker #(
  parameter int REG_W   = 5,
  parameter int IMM_W   = 10,
  parameter int TMP_REG = 17
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_s,
  input logic                    uop_valid,
  input logic                    uop_ready,
  input logic [2:0]              uop_op,
  input logic [REG_W-1:0]        uop_reg,
  input logic [REG_W-1:0]        uop_base,
  input logic signed [IMM_W-1:0] uop_imm,
  input logic                    uop_last,
  input logic                    bad_req
);
  p_mov_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_s) |=> (uop_valid && uop_op == 3'd0 && uop_reg == REG_W'(TMP_REG)));

  p_xfer_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && (uop_op == 3'd3 || uop_op == 3'd4)) |-> (uop_base == REG_W'(TMP_REG)));

  p_wb_is_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && (uop_op == 3'd1 || uop_op == 3'd2)) |-> uop_last);

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_ready && uop_last) |=> !uop_valid);

  p_bad_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_s) |=> (bad_req && !uop_valid));

  p_bad_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> !bad_req);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) && $stable(uop_reg)
      && $stable(uop_base) && $stable(uop_imm) && $stable(uop_last)));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !in_ready);
endmodule

bind lsm_uop_sequencer lsm_uop_checker #(
  .REG_W(REG_W), .IMM_W(IMM_W), .TMP_REG(TMP_REG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_s      (in_s),
  .uop_valid (uop_valid),
  .uop_ready (uop_ready),
  .uop_op    (uop_op),
  .uop_reg   (uop_reg),
  .uop_base  (uop_base),
  .uop_imm   (uop_imm),
  .uop_last  (uop_last),
  .bad_req   (bad_req)
);

// File: tb/lsm_uop_sequencer_tb.sv
module lsm_uop_sequencer_tb;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_base = '0;
  logic [15:0] in_list = '0;
  logic        in_up = 1'b0, in_pre = 1'b0, in_s = 1'b0, in_wb = 1'b0, in_load = 1'b0;
  logic        uop_valid;
  logic        uop_ready = 1'b0;
  logic [2:0]  uop_op;
  logic [4:0]  uop_reg, uop_base;
  logic signed [9:0] uop_imm;
  logic        uop_last, bad_req;
  logic [4:0]  uop_total;

  always #(PER/2) clk = ~clk;

  lsm_uop_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_list(in_list), .in_up(in_up), .in_pre(in_pre),
    .in_s(in_s), .in_wb(in_wb), .in_load(in_load), .uop_valid(uop_valid),
    .uop_ready(uop_ready), .uop_op(uop_op), .uop_reg(uop_reg),
    .uop_base(uop_base), .uop_imm(uop_imm), .uop_last(uop_last),
    .bad_req(bad_req), .uop_total(uop_total)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int e_op[20], e_reg[20], e_base[20], e_imm[20], e_last[20];
  int e_n;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ones(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) if (m[i]) c++;
    return c;
  endfunction

  task automatic build(input int b, input logic [15:0] m, input bit up, input bit pre,
                       input bit wb, input bit ld);
    int o;
    int st;
    st = up ? 4 : -4;
    o = pre ? st : 0;
    e_n = 0;
    e_op[0] = 0; e_reg[0] = 17; e_base[0] = b; e_imm[0] = 0; e_last[0] = 0;
    e_n = 1;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        e_op[e_n] = ld ? 3 : 4; e_reg[e_n] = i; e_base[e_n] = 17;
        e_imm[e_n] = o; e_last[e_n] = 0;
        o = o + st;
        e_n++;
      end
    end
    if (wb) begin
      e_op[e_n] = up ? 1 : 2; e_reg[e_n] = b; e_base[e_n] = b;
      e_imm[e_n] = 4 * ones(m); e_last[e_n] = 0;
      e_n++;
    end
    e_last[e_n-1] = 1;
  endtask

  task automatic run(input int b, input logic [15:0] m, input bit up, input bit pre,
                     input bit s, input bit wb, input bit ld, input int rdy_pct);
    int k;
    int guard;
    @(negedge clk);
    in_base = 4'(b); in_list = m; in_up = up; in_pre = pre; in_s = s;
    in_wb = wb; in_load = ld; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    if (s) begin
      chk("R7 bad_req pulse", int'(bad_req), 1);
      chk("R7 no uop", int'(uop_valid), 0);
      chk("R7 ready", int'(in_ready), 1);
      @(negedge clk);
      chk("R7 pulse one cycle", int'(bad_req), 0);
      return;
    end
    build(b, m, up, pre, wb, ld);
    chk("R11 total", int'(uop_total), e_n);
    k = 0;
    guard = 0;
    while (k < e_n && guard < 400) begin
      uop_ready = ($urandom % 100) < rdy_pct;
      #(PER/4);
      chk("R10 busy", int'(in_ready), 0);
      chk("R9 valid held", int'(uop_valid), 1);
      if (uop_ready) begin
        chk("R2/R3/R5 op", int'(uop_op), e_op[k]);
        chk("R2/R3/R5 reg", int'(uop_reg), e_reg[k]);
        chk("R2/R3 base", int'(uop_base), e_base[k]);
        chk("R4/R5 imm", int'(uop_imm), e_imm[k]);
        chk("R6 last", int'(uop_last), e_last[k]);
        k++;
      end
      @(negedge clk);
      guard++;
    end
    if (guard >= 400) chk("R9 stream stuck", 0, 1);
    uop_ready = 1'b0;
    chk("R6 stream ended", int'(uop_valid), 0);
    chk("R10 ready again", int'(in_ready), 1);
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      chk("watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1ce5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 uop_valid", int'(uop_valid), 0);
    chk("R1 bad_req", int'(bad_req), 0);
    chk("R1 total", int'(uop_total), 0);

    // R8 empty lists
    run(3, 16'h0000, 1, 0, 0, 1, 1, 100);
    run(5, 16'h0000, 0, 1, 0, 0, 0, 100);
    // R4 pre-up starts at +4, pre-down at -4
    run(2, 16'h0011, 1, 1, 0, 1, 0, 60);
    run(13, 16'hFFFF, 0, 1, 0, 1, 1, 50);
    run(0, 16'h8000, 1, 0, 0, 0, 1, 30);
    // R7 unsupported
    run(7, 16'h00F0, 1, 0, 1, 1, 1, 100);
    run(9, 16'hA5A5, 0, 0, 0, 1, 0, 20);

    for (int t = 0; t < 300; t++) begin
      run(int'($urandom % 16), 16'($urandom), bit'($urandom % 2), bit'($urandom % 2),
          ($urandom % 8) == 0, bit'($urandom % 2), bit'($urandom % 2), 40 + int'($urandom % 61));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule